// File: doc/BRIEF.md
# External Interrupt Line Controller

This block watches a bank of external interrupt pins, arranged as groups of eight lines. Each pin is brought into the clock domain through a two-flop synchronizer. A per-line trigger code then chooses which condition on the synchronized pin raises that line's pending flag: a rising edge, a falling edge, either edge, a low level or a high level. Pending flags are latched whether or not the line is masked. Each group has a mask register, and the mask only decides which pending flags reach the interrupt outputs.

The lines of the lower two groups (lines 0 to 15) each drive their own output wire. The lines of the upper two groups are merged into one shared output, which is high while any of them is pending and unmasked. Software controls the block through a plain register port: a single-cycle write strobe and a combinational read. To find the active lines in a group, software reads the pending register and ANDs it with the inverse of the mask.

Top module: `eirq_ctrl_top`

## Requirements
- R1: After reset, every trigger register reads 0x77777777 (an unused code on every line), every mask register reads 0xFF, every pending register reads 0, and all interrupt outputs are low.
- R2: `reg_addr[3:2]` selects the group and `reg_addr[1:0]` selects the register: 0 is trigger, 1 is mask (bits 7:0), 2 is pending (bits 7:0), and 3 reads as 0. Trigger and mask writes replace the register, and the register reads back what was written. Line b of a group uses trigger field bits [4b+3:4b] and bit b of mask and pending.
- R3: A pin is sampled by two flops in series. An edge is judged by comparing the synchronized value with its value one cycle earlier. A pin change set up before clock edge k appears in the pending flag after edge k+2, and not before.
- R4: Trigger code 3'b011 (field bits 2:0) sets the pending flag on a synchronized 0-to-1 transition.
- R5: Trigger code 3'b010 sets the pending flag on a synchronized 1-to-0 transition.
- R6: Trigger code 3'b100 sets the pending flag on either transition.
- R7: Code 3'b000 (low level) and code 3'b001 (high level) set the pending flag on every cycle the level is active, so a clear during an active level has no lasting effect.
- R8: Codes 3'b101, 3'b110 and 3'b111 never set a pending flag. Field bit 3 is stored and read back but does not affect triggering.
- R9: Writing the pending register clears each flag whose data bit is 1. Data bits of 0 leave their flags unchanged. When a trigger event and a clear of the same line fall in the same cycle, the flag stays set.
- R10: Pending flags latch while the line is masked (mask bit 1), and such a line drives no output.
- R11: `irq_line[i]` for lines 0 to 15 equals pending AND NOT mask of line i.
- R12: `irq_shared` is high exactly when at least one of lines 16 to 31 is pending and unmasked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| pins | input | 32 | Asynchronous external interrupt pins |
| reg_wr | input | 1 | Register write strobe, one cycle per write |
| reg_addr | input | 4 | Group (bits 3:2) and register select (bits 1:0) |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Combinational read data for `reg_addr` |
| irq_line | output | 16 | Per-line interrupt outputs for lines 0 to 15 |
| irq_shared | output | 1 | Shared interrupt for lines 16 to 31 |

## Verification
The hardest case to reach from the ports is a write-1 clear that lands in the same clock cycle as a new trigger event on the same line. Reaching it means timing the write against the hidden three-edge synchronizer and edge-detect pipeline. The stimulus reaches this case in two ways. A directed sequence raises a pin and issues the clear exactly two cycles later. Long random runs mix pin toggles with pending clears, and a cycle-accurate bench model judges every flag each cycle. Level-mode lines are also cleared while their level is held, to show the flag is set again.

// File: rtl/eirq_pkg.sv
package eirq_pkg;
  typedef enum logic [2:0] {
    TRIG_LOW  = 3'b000,
    TRIG_HIGH = 3'b001,
    TRIG_FALL = 3'b010,
    TRIG_RISE = 3'b011,
    TRIG_BOTH = 3'b100
  } trig_e;

  localparam logic [1:0] SEL_TRIG = 2'd0;
  localparam logic [1:0] SEL_MASK = 2'd1;
  localparam logic [1:0] SEL_PEND = 2'd2;

  // reset code for every trigger field: decodes to no trigger
  localparam logic [3:0] TRIG_RESET = 4'h7;
endpackage

// File: rtl/eirq_sync.sv
module eirq_sync #(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] cur_q,
  output logic [WIDTH-1:0] prev_q
);
  logic [WIDTH-1:0] meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      cur_q  <= '0;
      prev_q <= '0;
    end else begin
      meta_q <= din;
      cur_q  <= meta_q;
      prev_q <= cur_q;
    end
  end
endmodule

// File: rtl/eirq_detect.sv
module eirq_detect
  import eirq_pkg::*;
#(
  parameter int LINES = 8,
  parameter int FW    = 4
) (
  input  logic [LINES*FW-1:0] modes,
  input  logic [LINES-1:0]    cur,
  input  logic [LINES-1:0]    prev,
  output logic [LINES-1:0]    event_o
);
  for (genvar b = 0; b < LINES; b++) begin : g_line
    logic [2:0] code;
    assign code = modes[b*FW +: 3];
    always_comb begin
      unique case (code)
        TRIG_LOW:  event_o[b] = !cur[b];
        TRIG_HIGH: event_o[b] = cur[b];
        TRIG_FALL: event_o[b] = prev[b] && !cur[b];
        TRIG_RISE: event_o[b] = !prev[b] && cur[b];
        TRIG_BOTH: event_o[b] = prev[b] ^ cur[b];
        default:   event_o[b] = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/eirq_group.sv
module eirq_group
  import eirq_pkg::*;
#(
  parameter int LINES = 8,
  parameter int FW    = 4,
  localparam int DW   = LINES * FW
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] cur,
  input  logic [LINES-1:0] prev,
  input  logic             wr_trig,
  input  logic             wr_mask,
  input  logic             wr_pend,
  input  logic [DW-1:0]    wdata,
  output logic [DW-1:0]    trig_q,
  output logic [LINES-1:0] mask_q,
  output logic [LINES-1:0] pend_q,
  output logic [LINES-1:0] active
);
  logic [DW-1:0]    trig_d;
  logic [LINES-1:0] mask_d, pend_d, clr, ev;

  eirq_detect #(.LINES(LINES), .FW(FW)) u_det (
    .modes(trig_q), .cur(cur), .prev(prev), .event_o(ev)
  );

  always_comb begin
    trig_d = trig_q;
    mask_d = mask_q;
    if (wr_trig) trig_d = wdata;
    if (wr_mask) mask_d = wdata[LINES-1:0];
    clr    = wr_pend ? wdata[LINES-1:0] : '0;
    pend_d = (pend_q & ~clr) | ev;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trig_q <= {LINES{FW'(TRIG_RESET)}};
      mask_q <= '1;
      pend_q <= '0;
    end else begin
      trig_q <= trig_d;
      mask_q <= mask_d;
      pend_q <= pend_d;
    end
  end

  assign active = pend_q & ~mask_q;

  for (genvar b = 0; b < LINES; b++) begin : g_chk
    // R9: a new event beats a simultaneous clear
    a_r9_event_beats_clear: assert property (@(posedge clk) disable iff (!rst_n)
      ev[b] |=> pend_q[b]);
    // R9: a 1 written to a flag with no event clears it
    a_r9_w1c_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_pend && wdata[b] && !ev[b]) |=> !pend_q[b]);
    // R9: a set flag that is not cleared stays set
    a_r9_hold_set: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_q[b] && !(wr_pend && wdata[b])) |=> pend_q[b]);
    // R3: a flag never rises without a detected event
    a_r3_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
      (!pend_q[b] && !ev[b]) |=> !pend_q[b]);
  end
endmodule

// File: rtl/eirq_ctrl_top.sv
module eirq_ctrl_top
  import eirq_pkg::*;
#(
  parameter int GROUPS     = 4,
  parameter int LPG        = 8,
  parameter int FW         = 4,
  parameter int DED_GROUPS = 2,
  localparam int LINES     = GROUPS * LPG,
  localparam int DW        = LPG * FW,
  localparam int GW        = (GROUPS > 1) ? $clog2(GROUPS) : 1,
  localparam int AW        = GW + 2,
  localparam int DED       = DED_GROUPS * LPG
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] pins,
  input  logic             reg_wr,
  input  logic [AW-1:0]    reg_addr,
  input  logic [DW-1:0]    reg_wdata,
  output logic [DW-1:0]    reg_rdata,
  output logic [DED-1:0]   irq_line,
  output logic             irq_shared
);
  logic [1:0]       rst_pipe_q;
  logic             rst_sync_n;
  logic [LINES-1:0] cur, prev;
  logic [GW-1:0]    grp;
  logic [1:0]       sel;

  logic [DW-1:0]  trig_a [GROUPS];
  logic [LPG-1:0] mask_a [GROUPS];
  logic [LPG-1:0] pend_a [GROUPS];
  logic [LPG-1:0] act_a  [GROUPS];
  logic [GROUPS-1:0] grp_any;
  logic [GROUPS-1:0] grp_pend;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe_q[1];

  eirq_sync #(.WIDTH(LINES)) u_sync (
    .clk(clk), .rst_n(rst_sync_n), .din(pins), .cur_q(cur), .prev_q(prev)
  );

  assign grp = reg_addr[AW-1:2];
  assign sel = reg_addr[1:0];

  for (genvar g = 0; g < GROUPS; g++) begin : g_grp
    logic hit;
    assign hit = reg_wr && (grp == GW'(g));
    eirq_group #(.LINES(LPG), .FW(FW)) u_grp (
      .clk(clk), .rst_n(rst_sync_n),
      .cur(cur[g*LPG +: LPG]), .prev(prev[g*LPG +: LPG]),
      .wr_trig(hit && sel == SEL_TRIG),
      .wr_mask(hit && sel == SEL_MASK),
      .wr_pend(hit && sel == SEL_PEND),
      .wdata(reg_wdata),
      .trig_q(trig_a[g]), .mask_q(mask_a[g]), .pend_q(pend_a[g]),
      .active(act_a[g])
    );
    assign grp_any[g]  = |act_a[g];
    assign grp_pend[g] = |(pend_a[g] & ~mask_a[g]);
    if (g < DED_GROUPS) begin : g_ded
      assign irq_line[g*LPG +: LPG] = act_a[g];
    end
  end

  assign irq_shared = |grp_any[GROUPS-1:DED_GROUPS];

  always_comb begin
    reg_rdata = '0;
    unique case (sel)
      SEL_TRIG: reg_rdata = trig_a[grp];
      SEL_MASK: reg_rdata = DW'(mask_a[grp]);
      SEL_PEND: reg_rdata = DW'(pend_a[grp]);
      default:  reg_rdata = '0;
    endcase
  end

  // R12: the shared output never rises without an unmasked upper-group flag
  a_r12_shared_source: assert property (@(posedge clk) disable iff (!rst_sync_n)
    irq_shared |-> (|grp_pend[GROUPS-1:DED_GROUPS]));
  // R11: a dedicated output stays low while its whole group is masked
  a_r11_masked_quiet: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (&mask_a[0]) |-> (irq_line[LPG-1:0] == '0));
endmodule

// File: tb/eirq_ctrl_top_tb_top.sv
`timescale 1ns/1ps
module eirq_ctrl_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] pins;
  logic        reg_wr;
  logic [3:0]  reg_addr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic [15:0] irq_line;
  logic        irq_shared;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;
  string cur_req = "R1";

  logic [31:0] m_trig [4];
  logic [7:0]  m_mask [4];
  logic [7:0]  m_pend [4];
  logic [31:0] s1, s2, pv;

  eirq_ctrl_top dut_i (
    .clk(clk), .rst_n(rst_n), .pins(pins), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq_line(irq_line), .irq_shared(irq_shared)
  );

  always #5 clk = ~clk;

  function automatic logic ev_f(logic [3:0] f, logic c, logic p);
    case (f[2:0])
      3'd0: return !c;
      3'd1: return c;
      3'd2: return p && !c;
      3'd3: return !p && c;
      3'd4: return p ^ c;
      default: return 1'b0;
    endcase
  endfunction

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string what);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s (%s): actual %h expected %h", cur_req, what, act, exp);
    end
  endtask

  task automatic check_outs();
    logic [15:0] el;
    logic        es;
    for (int g = 0; g < 4; g++) begin
      reg_addr = {g[1:0], 2'b10};
      #0.3;
      chk(reg_rdata, {24'b0, m_pend[g]}, "pending");
    end
    el = {m_pend[1] & ~m_mask[1], m_pend[0] & ~m_mask[0]};
    es = |((m_pend[2] & ~m_mask[2]) | (m_pend[3] & ~m_mask[3]));
    chk({16'b0, irq_line}, {16'b0, el}, "R11 irq_line");
    chk({31'b0, irq_shared}, {31'b0, es}, "R12 irq_shared");
  endtask

  task automatic check_regs();
    for (int g = 0; g < 4; g++) begin
      reg_addr = {g[1:0], 2'b00}; #0.3; chk(reg_rdata, m_trig[g], "trigger reg");
      reg_addr = {g[1:0], 2'b01}; #0.3; chk(reg_rdata, {24'b0, m_mask[g]}, "mask reg");
      reg_addr = {g[1:0], 2'b11}; #0.3; chk(reg_rdata, 32'b0, "R2 unused slot");
    end
  endtask

  task automatic step(input logic [31:0] p, input logic we, input logic [3:0] a,
                      input logic [31:0] d);
    logic [7:0] e, clr;
    pins = p; reg_wr = we; reg_addr = a; reg_wdata = d;
    @(posedge clk);
    for (int g = 0; g < 4; g++) begin
      for (int b = 0; b < 8; b++)
        e[b] = ev_f(m_trig[g][b*4 +: 4], s2[g*8+b], pv[g*8+b]);
      clr = (we && a[3:2] == g[1:0] && a[1:0] == 2'd2) ? d[7:0] : 8'h00;
      m_pend[g] = (m_pend[g] & ~clr) | e;
      if (we && a[3:2] == g[1:0] && a[1:0] == 2'd0) m_trig[g] = d;
      if (we && a[3:2] == g[1:0] && a[1:0] == 2'd1) m_mask[g] = d[7:0];
    end
    pv = s2; s2 = s1; s1 = p;
    @(negedge clk);
    reg_wr = 1'b0;
    check_outs();
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(pins, 1'b0, 4'h0, 32'h0);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] p;
    void'($urandom(32'd20240611));
    pins = '0; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
    for (int g = 0; g < 4; g++) begin
      m_trig[g] = 32'h77777777; m_mask[g] = 8'hFF; m_pend[g] = 8'h00;
    end
    s1 = '0; s2 = '0; pv = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    cur_req = "R1";
    check_regs();
    check_outs();

    cur_req = "R2";
    step(pins, 1'b1, 4'b0000, 32'hA9876D5F);
    step(pins, 1'b1, 4'b1001, 32'h0000005A);
    check_regs();

    // set up: g0 rise, g1 fall, g2 both, g3 alternating high/low level
    cur_req = "R2 setup";
    step(pins, 1'b1, 4'b0000, 32'h33333333);
    step(pins, 1'b1, 4'b0100, 32'h22222222);
    step(pins, 1'b1, 4'b1000, 32'h44444444);
    step(pins, 1'b1, 4'b1100, 32'h01010101);
    for (int g = 0; g < 4; g++) step(pins, 1'b1, {g[1:0], 2'b01}, 32'h0);
    for (int g = 0; g < 4; g++) step(pins, 1'b1, {g[1:0], 2'b10}, 32'hFF);

    cur_req = "R3 R4 rising";
    step(pins | 32'h0000_0008, 1'b0, 4'h0, 32'h0);
    idle(4);
    step(pins, 1'b1, 4'b0010, 32'h08);
    step(pins & ~32'h0000_0008, 1'b0, 4'h0, 32'h0);
    idle(4);

    cur_req = "R5 falling";
    step(pins | 32'h0000_0400, 1'b0, 4'h0, 32'h0);
    idle(4);
    step(pins & ~32'h0000_0400, 1'b0, 4'h0, 32'h0);
    idle(4);

    cur_req = "R6 both";
    step(pins | 32'h0002_0000, 1'b0, 4'h0, 32'h0);
    idle(4);
    step(pins, 1'b1, 4'b1010, 32'h02);
    step(pins & ~32'h0002_0000, 1'b0, 4'h0, 32'h0);
    idle(4);

    cur_req = "R7 level";
    step(pins | 32'h0100_0000, 1'b0, 4'h0, 32'h0);
    idle(3);
    for (int i = 0; i < 4; i++) step(pins, 1'b1, 4'b1110, 32'hFF);
    step(pins & ~32'h0100_0000, 1'b0, 4'h0, 32'h0);
    idle(3);
    step(pins, 1'b1, 4'b1110, 32'hFF);

    cur_req = "R8 unused codes";
    step(pins, 1'b1, 4'b0000, 32'hF76DF76D);
    step(pins, 1'b1, 4'b0010, 32'hFF);
    for (int i = 0; i < 6; i++) step(pins ^ 32'h0000_00FF, 1'b0, 4'h0, 32'h0);
    step(pins, 1'b1, 4'b0000, 32'h0000000C);
    step(pins ^ 32'h0000_0001, 1'b0, 4'h0, 32'h0);
    idle(4);

    cur_req = "R9 w1c";
    step(pins, 1'b1, 4'b0010, 32'h00);
    step(pins, 1'b1, 4'b0010, 32'h01);
    step(pins, 1'b0, 4'h0, 32'h0);
    step(pins, 1'b1, 4'b0000, 32'h00000003);
    step(pins & ~32'h1, 1'b0, 4'h0, 32'h0);
    idle(4);
    step(pins | 32'h1, 1'b0, 4'h0, 32'h0);
    step(pins, 1'b0, 4'h0, 32'h0);
    step(pins, 1'b1, 4'b0010, 32'hFF);
    idle(2);

    cur_req = "R10 masked";
    step(pins, 1'b1, 4'b0101, 32'hFF);
    step(pins | 32'h0000_2000, 1'b0, 4'h0, 32'h0);
    idle(3);
    step(pins & ~32'h0000_2000, 1'b0, 4'h0, 32'h0);
    idle(4);
    step(pins, 1'b1, 4'b0101, 32'h00);

    cur_req = "R11 R12 random";
    for (int i = 0; i < 3000; i++) begin
      logic        we;
      logic [3:0]  a;
      logic [31:0] d;
      p  = pins ^ ($urandom & $urandom & $urandom);
      we = ($urandom % 4) == 0;
      a  = {2'($urandom % 4), 2'($urandom % 3)};
      d  = $urandom;
      step(p, we, a, d);
    end
    cur_req = "R2 final";
    check_regs();

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule